// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is the storage element of one programmable logic cell. A static configuration word turns it into a D, T, JK or SR flip-flop, or into a transparent latch. It also picks where the primary data comes from, which clock drives the cell and whether a clock enable applies. The same word selects the sources of asynchronous clear and set. It also chooses whether the cell output and the buried feedback each carry the stored state or the cell's combinational logic result.

The block runs on one system clock `clk`. The cell clocks (three global clocks and one product-term clock) arrive as sampled signals. The block detects a rising edge as the first system-clock edge at which the selected cell clock is seen high after being low, and the state updates on that same edge. Asynchronous clear and set mask the outputs at once, combinationally, and force the stored state on the next system-clock edge. The configuration inputs are expected to change only while the cell clocks are low or during reset.

Top module: `mcell_reg`

## Requirements
- R1: `cfg_dsel` selects the primary data input: 0 = `xor_in`, 1 = `pt_d`, 2 = `pin_in`, 3 = `xor_in`.
- R2: `cfg_mode` 0 is D mode (state takes the data) and 1 is T mode (state inverts when the data is 1 and holds when it is 0). Codes 5 to 7 act as D.
- R3: `cfg_mode` 2 is JK and 3 is SR. The data is J or S and `pt_aux` is K or R. For JK: 00 holds, 01 clears, 10 sets, 11 inverts. For SR: 00 holds, 01 clears, 10 sets, 11 holds.
- R4: `cfg_mode` 4 is a latch. On every system-clock edge where the selected cell clock is high, the state takes the data. While that clock is low, the state holds.
- R5: `cfg_clksel` 0 to 2 selects `gclk[0..2]` and 3 selects `pt_clk`. In the edge-triggered modes, the state changes only on a rising edge of the selected clock. Edges on clocks that are not selected have no effect.
- R6: When `cfg_ce_en` is 1 and a global clock is selected, `pt_ce` low blocks updates. With `pt_clk` selected, `pt_ce` has no effect.
- R7: `cfg_arsel` picks the clear source: 0 = none, 1 = `gclr`, 2 = `pt_ar`, 3 = `gclr` OR `pt_ar`. An active clear forces the registered value to 0 at once, and the state stays 0 after the clear is released.
- R8: When `cfg_ap_en` is 1, `pt_ap` forces the registered value to 1. When clear and set are active together, clear wins.
- R9: `cfg_out_reg` 1 makes `cell_out` carry the registered value. When it is 0, `cell_out` follows `xor_in` combinationally.
- R10: `cfg_fb_reg` selects the same choice for `fb_out`, independently of `cfg_out_reg`.
- R11: A system-clock edge with `rst_n` low sets the state to 0 and forgets any earlier cell-clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Storage mode |
| cfg_dsel | input | 2 | Primary data source select |
| cfg_clksel | input | 2 | Cell clock select |
| cfg_ce_en | input | 1 | Enable product-term clock enable |
| cfg_arsel | input | 2 | Asynchronous clear source select |
| cfg_ap_en | input | 1 | Enable asynchronous set |
| cfg_out_reg | input | 1 | Cell output: 1 registered, 0 combinational |
| cfg_fb_reg | input | 1 | Feedback: 1 registered, 0 combinational |
| gclk | input | 3 | Global cell clocks |
| pt_clk | input | 1 | Product-term cell clock |
| pt_ce | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_ar | input | 1 | Product-term clear |
| pt_ap | input | 1 | Product-term set |
| xor_in | input | 1 | Cell logic result |
| pt_d | input | 1 | Dedicated product-term data |
| pin_in | input | 1 | I/O pin data |
| pt_aux | input | 1 | K or R input for JK/SR modes |
| cell_out | output | 1 | Cell output |
| fb_out | output | 1 | Buried feedback |

## Verification
The assertions assume that every cell clock is sampled by `clk` and stays high or low for at least one system cycle. They also assume that the configuration word holds still while an update is pending. The stimulus meets both by changing inputs only at falling edges of `clk` and by holding each clock pulse high for exactly one system cycle. It changes the configuration only while the cell clocks are low and reset is applied. Clear and set are raised and dropped away from cell-clock pulses, so the clear and set checks never race an update.

// File: rtl/mcell_pkg.sv
// Shared encodings for the macrocell storage cell.
// Assumes: configuration fields are decoded by casting into these types.
package mcell_pkg;

    typedef enum logic [2:0] {
        MD_D     = 3'd0,
        MD_T     = 3'd1,
        MD_JK    = 3'd2,
        MD_SR    = 3'd3,
        MD_LATCH = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        DS_XOR  = 2'd0,
        DS_PT   = 2'd1,
        DS_PIN  = 2'd2,
        DS_XOR2 = 2'd3
    } dsel_e;

    typedef enum logic [1:0] {
        AR_OFF  = 2'd0,
        AR_GLB  = 2'd1,
        AR_PT   = 2'd2,
        AR_BOTH = 2'd3
    } arsel_e;

endpackage

// File: rtl/mcell_clk_gate.sv
// Cell clock selection, edge detection and clock-enable gating.
// Produces a one-cycle update strobe in the system clock domain.
// Assumes: cell clocks are sampled signals held at least one system cycle.
module mcell_clk_gate #(
    parameter int GCLK_N = 3,
    localparam int CLK_SEL_W = $clog2(GCLK_N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GCLK_N-1:0]    gclk,
    input  logic                 pt_clk,
    input  logic                 pt_ce,
    input  logic [CLK_SEL_W-1:0] cfg_clksel,
    input  logic                 cfg_ce_en,
    input  logic                 level_mode,
    output logic                 upd
);
    localparam logic [CLK_SEL_W-1:0] PT_SEL = CLK_SEL_W'(GCLK_N);

    logic [GCLK_N:0] clk_pool;
    logic            sel_clk;
    logic            sel_prev;
    logic            is_global;
    logic            ce_ok;

    assign clk_pool  = {pt_clk, gclk};
    assign is_global = (cfg_clksel < PT_SEL);

    // Pick the configured cell clock out of the pool.
    always_comb begin : pick_clock
        sel_clk = 1'b0;
        for (int i = 0; i <= GCLK_N; i++) begin
            if (cfg_clksel == CLK_SEL_W'(i)) sel_clk = clk_pool[i];
        end
    end

    // Remember the last sampled level of the selected clock.
    always_ff @(posedge clk) begin : track_level
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel_clk;
    end

    // The enable only gates global clocks.
    always_comb begin : gate_enable
        ce_ok = !(is_global && cfg_ce_en && !pt_ce);
        upd   = ce_ok && (level_mode ? sel_clk : (sel_clk && !sel_prev));
    end

    AST_CE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_global && cfg_ce_en && !pt_ce) |-> !upd); // R6
    AST_PT_CE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_global && !level_mode && pt_clk && !sel_prev) |-> upd); // R6

endmodule

// File: rtl/mcell_next.sv
// Next-state function for the selectable storage modes.
// Assumes: din is J/S/D/T and aux is K/R; unknown mode codes act as D.
module mcell_next
    import mcell_pkg::*;
(
    input  mode_e mode,
    input  logic  q,
    input  logic  din,
    input  logic  aux,
    output logic  q_nxt
);
    // Compute the value stored on an update event.
    always_comb begin : next_state
        case (mode)
            MD_T: q_nxt = q ^ din;
            MD_JK: begin
                case ({din, aux})
                    2'b01:   q_nxt = 1'b0;
                    2'b10:   q_nxt = 1'b1;
                    2'b11:   q_nxt = ~q;
                    default: q_nxt = q;
                endcase
            end
            MD_SR: begin
                case ({din, aux})
                    2'b01:   q_nxt = 1'b0;
                    2'b10:   q_nxt = 1'b1;
                    default: q_nxt = q;
                endcase
            end
            default: q_nxt = din;
        endcase
    end

endmodule

// File: rtl/mcell_async.sv
// Source selection for the asynchronous clear and set of the cell.
// Assumes: clear priority over set is resolved by the consumer.
module mcell_async
    import mcell_pkg::*;
(
    input  arsel_e arsel,
    input  logic   ap_en,
    input  logic   gclr,
    input  logic   pt_ar,
    input  logic   pt_ap,
    output logic   ar_act,
    output logic   ap_act
);
    // Form the clear from its configured sources and gate the set.
    always_comb begin : pick_sources
        case (arsel)
            AR_GLB:  ar_act = gclr;
            AR_PT:   ar_act = pt_ar;
            AR_BOTH: ar_act = gclr | pt_ar;
            default: ar_act = 1'b0;
        endcase
        ap_act = ap_en & pt_ap;
    end

endmodule

// File: rtl/mcell_reg.sv
// Configurable macrocell storage cell: D/T/JK/SR flip-flop or latch,
// selectable data, clock, enable, clear and set sources, and independent
// registered/combinational choice for the output and buried feedback.
// Assumes: configuration is static while cell clocks toggle.
module mcell_reg
    import mcell_pkg::*;
#(
    parameter int GCLK_N = 3,
    localparam int CLK_SEL_W = $clog2(GCLK_N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cfg_mode,
    input  logic [1:0]           cfg_dsel,
    input  logic [CLK_SEL_W-1:0] cfg_clksel,
    input  logic                 cfg_ce_en,
    input  logic [1:0]           cfg_arsel,
    input  logic                 cfg_ap_en,
    input  logic                 cfg_out_reg,
    input  logic                 cfg_fb_reg,
    input  logic [GCLK_N-1:0]    gclk,
    input  logic                 pt_clk,
    input  logic                 pt_ce,
    input  logic                 gclr,
    input  logic                 pt_ar,
    input  logic                 pt_ap,
    input  logic                 xor_in,
    input  logic                 pt_d,
    input  logic                 pin_in,
    input  logic                 pt_aux,
    output logic                 cell_out,
    output logic                 fb_out
);
    mode_e mode;
    logic  din;
    logic  upd;
    logic  q_state;
    logic  q_nxt;
    logic  q_eff;
    logic  ar_act;
    logic  ap_act;

    assign mode = mode_e'(cfg_mode);

    // Route the configured primary data source.
    always_comb begin : pick_data
        case (dsel_e'(cfg_dsel))
            DS_PT:   din = pt_d;
            DS_PIN:  din = pin_in;
            default: din = xor_in;
        endcase
    end

    mcell_clk_gate #(.GCLK_N(GCLK_N)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .gclk       (gclk),
        .pt_clk     (pt_clk),
        .pt_ce      (pt_ce),
        .cfg_clksel (cfg_clksel),
        .cfg_ce_en  (cfg_ce_en),
        .level_mode (mode == MD_LATCH),
        .upd        (upd)
    );

    mcell_next u_next (
        .mode  (mode),
        .q     (q_state),
        .din   (din),
        .aux   (pt_aux),
        .q_nxt (q_nxt)
    );

    mcell_async u_async (
        .arsel  (arsel_e'(cfg_arsel)),
        .ap_en  (cfg_ap_en),
        .gclr   (gclr),
        .pt_ar  (pt_ar),
        .pt_ap  (pt_ap),
        .ar_act (ar_act),
        .ap_act (ap_act)
    );

    // Hold the stored bit; clear beats set, both beat a clocked update.
    always_ff @(posedge clk) begin : state_reg
        if (!rst_n)      q_state <= 1'b0;
        else if (ar_act) q_state <= 1'b0;
        else if (ap_act) q_state <= 1'b1;
        else if (upd)    q_state <= q_nxt;
    end

    // Asynchronous overrides reach the outputs without waiting for a clock.
    always_comb begin : drive_outputs
        q_eff    = ar_act ? 1'b0 : (ap_act ? 1'b1 : q_state);
        cell_out = cfg_out_reg ? q_eff : xor_in;
        fb_out   = cfg_fb_reg  ? q_eff : xor_in;
    end

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !ar_act && !ap_act) |=> $stable(q_state)); // R5
    AST_T_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == MD_T && din && !ar_act && !ap_act) |=> (q_state != $past(q_state))); // R2
    AST_CLEAR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ar_act |=> !q_state); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_act && ap_act) |=> !q_state); // R8
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_act && !ar_act) |=> q_state); // R8

endmodule

// File: tb/tb_mcell_reg.sv
// Directed bench for mcell_reg: one task per scenario, each self-checking.
module tb_mcell_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic [1:0] cfg_dsel = '0;
    logic [1:0] cfg_clksel = '0;
    logic       cfg_ce_en = 1'b0;
    logic [1:0] cfg_arsel = '0;
    logic       cfg_ap_en = 1'b0;
    logic       cfg_out_reg = 1'b1;
    logic       cfg_fb_reg = 1'b1;
    logic [2:0] gclk = '0;
    logic       pt_clk = 1'b0;
    logic       pt_ce = 1'b1;
    logic       gclr = 1'b0;
    logic       pt_ar = 1'b0;
    logic       pt_ap = 1'b0;
    logic       xor_in = 1'b0;
    logic       pt_d = 1'b0;
    logic       pin_in = 1'b0;
    logic       pt_aux = 1'b0;
    logic       cell_out;
    logic       fb_out;

    int n_chk = 0;
    int n_bad = 0;

    mcell_reg dut (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Reset with a fresh configuration; all cell clocks low.
    task automatic setup(input logic [2:0] m, input logic [1:0] ds, input logic [1:0] cs,
                         input logic ce, input logic [1:0] ar, input logic ap);
        @(negedge clk);
        rst_n = 1'b0; gclk = '0; pt_clk = 1'b0; gclr = 1'b0; pt_ar = 1'b0; pt_ap = 1'b0;
        cfg_mode = m; cfg_dsel = ds; cfg_clksel = cs; cfg_ce_en = ce;
        cfg_arsel = ar; cfg_ap_en = ap; cfg_out_reg = 1'b1; cfg_fb_reg = 1'b1;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-system-cycle pulse on cell clock c (3 = product-term clock).
    task automatic tick(input int c);
        @(negedge clk);
        if (c == 3) pt_clk = 1'b1; else gclk[c] = 1'b1;
        @(negedge clk);
        if (c == 3) pt_clk = 1'b0; else gclk[c] = 1'b0;
        #1;
    endtask

    function automatic logic ref_next(input int m, input logic q, input logic d, input logic a);
        if (m == 1) return q ^ d;
        if (m == 2) return (d && a) ? ~q : (d ? 1'b1 : (a ? 1'b0 : q));
        if (m == 3) return (d && !a) ? 1'b1 : ((!d && a) ? 1'b0 : q);
        return d;
    endfunction

    task automatic t_reset();
        setup(3'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0);
        #1;
        check("R11 state after reset", cell_out, 1'b0);
        check("R11 feedback after reset", fb_out, 1'b0);
    endtask

    task automatic t_dsel();
        for (int s = 0; s < 4; s++) begin
            setup(3'd0, 2'(s), 2'd0, 1'b0, 2'd0, 1'b0);
            xor_in = (s == 0 || s == 3); pt_d = (s == 1); pin_in = (s == 2);
            tick(0);
            check("R1 selected source high", cell_out, 1'b1);
            xor_in = !(s == 0 || s == 3); pt_d = !(s == 1); pin_in = !(s == 2);
            tick(0);
            check("R1 selected source low", cell_out, 1'b0);
        end
        xor_in = 1'b0; pt_d = 1'b0; pin_in = 1'b0;
    endtask

    task automatic t_clksel();
        for (int c = 0; c < 4; c++) begin
            setup(3'd0, 2'd0, 2'(c), 1'b0, 2'd0, 1'b0);
            xor_in = 1'b1;
            tick((c + 1) % 4);
            check("R5 unselected clock ignored", cell_out, 1'b0);
            tick(c);
            check("R5 selected clock updates", cell_out, 1'b1);
        end
        xor_in = 1'b0;
    endtask

    task automatic t_toggle();
        logic q = 1'b0;
        setup(3'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            xor_in = (i != 2);
            tick(0);
            q = ref_next(1, q, xor_in, 1'b0);
            check("R2 T mode", cell_out, q);
        end
        setup(3'd6, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0);
        xor_in = 1'b1; tick(0);
        check("R2 spare code acts as D", cell_out, 1'b1);
        xor_in = 1'b0;
    endtask

    task automatic t_jksr(input int m);
        logic q = 1'b0;
        setup(3'(m), 2'd0, 2'd0, 1'b0, 2'd0, 1'b0);
        for (int r = 0; r < 2; r++) begin
            for (int p = 0; p < 4; p++) begin
                xor_in = p[1]; pt_aux = p[0];
                tick(0);
                q = ref_next(m, q, xor_in, pt_aux);
                check(m == 2 ? "R3 JK table" : "R3 SR table", cell_out, q);
            end
            xor_in = 1'b1; pt_aux = 1'b0; tick(0); q = 1'b1;
            check("R3 set before repeat", cell_out, q);
        end
        xor_in = 1'b0; pt_aux = 1'b0;
    endtask

    task automatic t_latch();
        setup(3'd4, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0);
        @(negedge clk); gclk[0] = 1'b1; xor_in = 1'b1;
        @(negedge clk); #1;
        check("R4 transparent takes 1", cell_out, 1'b1);
        xor_in = 1'b0;
        @(negedge clk); #1;
        check("R4 transparent takes 0", cell_out, 1'b0);
        gclk[0] = 1'b0; xor_in = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        check("R4 holds while clock low", cell_out, 1'b0);
    endtask

    task automatic t_enable();
        setup(3'd0, 2'd0, 2'd1, 1'b1, 2'd0, 1'b0);
        xor_in = 1'b1; pt_ce = 1'b0;
        tick(1);
        check("R6 enable low blocks global edge", cell_out, 1'b0);
        pt_ce = 1'b1;
        tick(1);
        check("R6 enable high passes edge", cell_out, 1'b1);
        setup(3'd0, 2'd0, 2'd3, 1'b1, 2'd0, 1'b0);
        xor_in = 1'b1; pt_ce = 1'b0;
        tick(3);
        check("R6 enable ignored on product-term clock", cell_out, 1'b1);
        pt_ce = 1'b1; xor_in = 1'b0;
    endtask

    task automatic t_clear();
        for (int a = 0; a < 4; a++) begin
            for (int src = 0; src < 2; src++) begin
                logic hit;
                setup(3'd0, 2'd0, 2'd0, 1'b0, 2'(a), 1'b0);
                hit = (src == 0) ? (a == 1 || a == 3) : (a == 2 || a == 3);
                xor_in = 1'b1; tick(0); xor_in = 1'b0;
                @(negedge clk);
                if (src == 0) gclr = 1'b1; else pt_ar = 1'b1;
                #1;
                check("R7 clear acts at once", cell_out, !hit);
                @(negedge clk);
                gclr = 1'b0; pt_ar = 1'b0;
                #1;
                check("R7 state after clear released", cell_out, !hit);
            end
        end
    endtask

    task automatic t_preset();
        setup(3'd0, 2'd0, 2'd0, 1'b0, 2'd2, 1'b0);
        @(negedge clk); pt_ap = 1'b1; #1;
        check("R8 set disabled has no effect", cell_out, 1'b0);
        @(negedge clk); pt_ap = 1'b0; #1;
        check("R8 state untouched by disabled set", cell_out, 1'b0);
        setup(3'd0, 2'd0, 2'd2, 1'b0, 2'd2, 1'b1);
        @(negedge clk); pt_ap = 1'b1; #1;
        check("R8 set acts at once", cell_out, 1'b1);
        @(negedge clk); pt_ap = 1'b0; #1;
        check("R8 set sticks", cell_out, 1'b1);
        @(negedge clk); pt_ap = 1'b1; pt_ar = 1'b1; #1;
        check("R8 clear wins over set", cell_out, 1'b0);
        @(negedge clk); pt_ap = 1'b0; pt_ar = 1'b0; #1;
        check("R8 state cleared after both", cell_out, 1'b0);
    endtask

    task automatic t_outsel();
        setup(3'd0, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0);
        pt_d = 1'b1; tick(0); pt_d = 1'b0;
        @(negedge clk);
        cfg_out_reg = 1'b0; cfg_fb_reg = 1'b1; xor_in = 1'b0; #1;
        check("R9 combinational output low", cell_out, 1'b0);
        check("R10 feedback stays registered", fb_out, 1'b1);
        xor_in = 1'b1; #1;
        check("R9 combinational output follows", cell_out, 1'b1);
        @(negedge clk);
        cfg_out_reg = 1'b1; cfg_fb_reg = 1'b0; xor_in = 1'b0; #1;
        check("R9 registered output", cell_out, 1'b1);
        check("R10 combinational feedback", fb_out, 1'b0);
    endtask

    initial begin : watchdog
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_dsel();
        t_clksel();
        t_toggle();
        t_jksr(2);
        t_jksr(3);
        t_latch();
        t_enable();
        t_clear();
        t_preset();
        t_outsel();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule